// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block services a ring of transmit descriptors kept in a local memory. The host and the engine share that memory. Each descriptor takes two 32-bit words. The even word holds control and status. The odd word holds the buffer address. The host fills in the length and flags, then sets the ready bit to hand the descriptor to the engine. The engine sends a frame request to a MAC transmit core. It waits for that core to report completion, and then writes the completion status back into the same descriptor with ready cleared. The host can then reclaim the descriptor.

A count input sets how many of the leading descriptors form the transmit ring. A wrap flag in a descriptor can close the ring early. Two sticky interrupt sources record good and failed frames. The host clears a source by writing a one to it, and a mask selects which sources drive the interrupt line. An enable input gates the start of new frames only. A frame already in flight always completes.

Top module: `txbd_engine`

## Requirements
- R1: After reset, no frame request is pending, both interrupt sources and the interrupt line are low, every descriptor word reads zero, and processing starts at descriptor 0.
- R2: A descriptor is started only when its ready bit (control bit 15) is set, the enable input is high and the effective count is non-zero. Otherwise the engine keeps polling the same descriptor and does not advance.
- R3: While a request is pending, the request carries the following fields, held stable until completion: the odd word as buffer address, CRC enable from control bit 11, pad from control bit 12, and the length from control bits 31:16.
- R4: When pad is set and the stored length is below 64, the requested length is 64. In every other case it is the stored length.
- R5: On completion, the control word is rewritten as follows: bit 15 is cleared, bits 8:0 take the status (bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun), and all other bits keep their value. The request drops in the following cycle.
- R6: After a descriptor with wrap (control bit 13) set, or after index count-1, the next descriptor is 0. Otherwise the index goes up by one.
- R7: When control bit 14 is set, completion sets source bit 1 if carrier lost, late collision, retry limit or underrun is reported, and sets source bit 0 otherwise. Deferral and retry count alone do not count as errors. With bit 14 clear, neither source bit changes.
- R8: The interrupt line is high exactly when a source bit and its mask bit are both one. A one on a clear bit resets that source bit, unless the same bit is being set in that cycle.
- R9: Dropping the enable input during a frame still lets that frame complete and write back, but no further descriptor starts until the input is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Allows new descriptors to start |
| tx_count | input | 8 | Descriptors in the ring; values above 128 act as 128 |
| int_mask | input | 2 | Interrupt mask, bit 0 good frame, bit 1 error |
| int_clear | input | 2 | Write-one-to-clear pulses for the sources |
| host_addr | input | 8 | Descriptor word index (2*index + word) |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_addr |
| frm_req | output | 1 | Frame request pending |
| frm_addr | output | 32 | Buffer address of the frame |
| frm_len | output | 16 | Length to send, after padding |
| frm_pad | output | 1 | Pad flag of the frame |
| frm_crc | output | 1 | CRC append flag of the frame |
| frm_done | input | 1 | One-cycle completion from the MAC |
| frm_status | input | 9 | Completion status, layout as in R5 |
| int_src | output | 2 | Sticky interrupt sources |
| irq | output | 1 | Masked interrupt line |

## Verification
A table of frames drives the ring through several kinds of frame. Some are short with pad set and some short without. Others are exactly 64 bytes or long. The completion statuses cover clean completion, deferral alone, a high retry count alone, and each error kind, with the interrupt bit both set and clear. This separates padding from plain length, and errors from harmless status. It also shows that stale status bits get overwritten. The table runs past the end of a four-entry ring, so the index order shows the return after the last slot. Directed cases then run a descriptor left unready, a wrap flag inside a larger ring, enable dropped in mid-frame, a zero count, and each mask and clear combination.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    // control word bit positions (the host and the engine both decode these)
    localparam int CB_READY = 15;
    localparam int CB_IRQ   = 14;
    localparam int CB_WRAP  = 13;
    localparam int CB_PAD   = 12;
    localparam int CB_CRC   = 11;
    localparam int ST_W     = 9;

    typedef struct packed {
        logic       underrun;
        logic [3:0] retries;
        logic       retry_lim;
        logic       late_coll;
        logic       deferred;
        logic       carrier_lost;
    } tx_stat_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              pad;
        logic              crc;
        logic              irq_en;
        logic              wrap;
    } tx_job_t;

    typedef enum logic {
        SEQ_POLL = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    function automatic logic is_fault(tx_stat_t s);
        return s.carrier_lost | s.late_coll | s.retry_lim | s.underrun;
    endfunction

    function automatic logic [LEN_W-1:0] wire_len(logic [LEN_W-1:0] len,
                                                   logic pad,
                                                   logic [LEN_W-1:0] min_len);
        return (pad && (len < min_len)) ? min_len : len;
    endfunction

    function automatic logic [WORD_W-1:0] merge_status(logic [WORD_W-1:0] ctl,
                                                       tx_stat_t st);
        logic [WORD_W-1:0] r;
        r = ctl;
        r[CB_READY] = 1'b0;
        r[ST_W-1:0] = st;
        return r;
    endfunction

endpackage

// File: rtl/txbd_store.sv
module txbd_store #(
    parameter int MAX_DESC = 128,
    localparam int WORDS = 2 * MAX_DESC,
    localparam int WAW   = $clog2(WORDS),
    localparam int IW    = $clog2(MAX_DESC)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAW-1:0]              host_addr,
    input  logic                        host_we,
    input  logic [txbd_pkg::WORD_W-1:0] host_wdata,
    output logic [txbd_pkg::WORD_W-1:0] host_rdata,
    input  logic [IW-1:0]               eng_idx,
    output logic [txbd_pkg::WORD_W-1:0] eng_ctl,
    output logic [txbd_pkg::WORD_W-1:0] eng_buf,
    input  logic                        wb_en,
    input  logic [txbd_pkg::WORD_W-1:0] wb_data
);
    logic [txbd_pkg::WORD_W-1:0] mem [WORDS];

    // engine write-back is placed last so it wins a same-word collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_addr] <= host_wdata;
            if (wb_en)   mem[{eng_idx, 1'b0}] <= wb_data;
        end
    end

    assign host_rdata = mem[host_addr];
    assign eng_ctl    = mem[{eng_idx, 1'b0}];
    assign eng_buf    = mem[{eng_idx, 1'b1}];
endmodule

// File: rtl/txbd_seq.sv
module txbd_seq
    import txbd_pkg::*;
#(
    parameter int MAX_DESC  = 128,
    parameter int MIN_FRAME = 64,
    localparam int IW    = $clog2(MAX_DESC),
    localparam int CNT_W = $clog2(MAX_DESC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_enable,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [WORD_W-1:0] desc_ctl,
    input  logic [WORD_W-1:0] desc_buf,
    input  logic              frm_done,
    input  tx_stat_t          frm_status,
    output logic [IW-1:0]     idx,
    output logic              frm_req,
    output tx_job_t           job,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_data,
    output logic              ev_good,
    output logic              ev_err
);
    localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAX_DESC);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    seq_state_t       state;
    logic [CNT_W-1:0] n_eff;
    logic [CNT_W-1:0] idx_ext;
    logic             out_of_range;
    logic             last_slot;
    logic             launch;
    logic             fault;

    assign n_eff        = (tx_count > MAX_N) ? MAX_N : tx_count;
    assign idx_ext      = CNT_W'(idx);
    assign out_of_range = (idx_ext >= n_eff);
    assign last_slot    = ((idx_ext + CNT_W'(1)) >= n_eff);
    assign launch       = tx_enable && (n_eff != '0) && !out_of_range
                          && desc_ctl[CB_READY];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_POLL;
            idx   <= '0;
            job   <= '0;
        end else begin
            case (state)
                SEQ_POLL: begin
                    if (out_of_range) begin
                        idx <= '0;
                    end else if (launch) begin
                        job.addr   <= desc_buf;
                        job.len    <= wire_len(desc_ctl[WORD_W-1:WORD_W-LEN_W],
                                               desc_ctl[CB_PAD], MIN_L);
                        job.pad    <= desc_ctl[CB_PAD];
                        job.crc    <= desc_ctl[CB_CRC];
                        job.irq_en <= desc_ctl[CB_IRQ];
                        job.wrap   <= desc_ctl[CB_WRAP];
                        state      <= SEQ_BUSY;
                    end
                end
                SEQ_BUSY: begin
                    if (frm_done) begin
                        state <= SEQ_POLL;
                        idx   <= (job.wrap || last_slot) ? '0 : idx + 1'b1;
                    end
                end
                default: state <= SEQ_POLL;
            endcase
        end
    end

    assign frm_req = (state == SEQ_BUSY);
    assign wb_en   = frm_req && frm_done;
    assign wb_data = merge_status(desc_ctl, frm_status);
    assign fault   = is_fault(frm_status);
    assign ev_good = wb_en && job.irq_en && !fault;
    assign ev_err  = wb_en && job.irq_en && fault;
endmodule

// File: rtl/txbd_irq.sv
module txbd_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_good,
    input  logic       ev_err,
    input  logic [1:0] int_clear,
    input  logic [1:0] int_mask,
    output logic [1:0] int_src,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) int_src <= '0;
        else     int_src <= (int_src & ~int_clear) | {ev_err, ev_good};
    end

    assign irq = |(int_src & int_mask);
endmodule

// File: rtl/txbd_engine.sv
module txbd_engine
    import txbd_pkg::*;
#(
    parameter int MAX_DESC  = 128,
    parameter int MIN_FRAME = 64,
    localparam int WAW   = $clog2(2 * MAX_DESC),
    localparam int CNT_W = $clog2(MAX_DESC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_enable,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [1:0]        int_mask,
    input  logic [1:0]        int_clear,
    input  logic [WAW-1:0]    host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              frm_req,
    output logic [31:0]       frm_addr,
    output logic [15:0]       frm_len,
    output logic              frm_pad,
    output logic              frm_crc,
    input  logic              frm_done,
    input  logic [8:0]        frm_status,
    output logic [1:0]        int_src,
    output logic              irq
);
    localparam int IW = $clog2(MAX_DESC);

    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] desc_ctl, desc_buf, wb_data;
    logic              wb_en, ev_good, ev_err;
    tx_job_t           job;

    txbd_store #(.MAX_DESC(MAX_DESC)) u_store (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_idx    (idx),
        .eng_ctl    (desc_ctl),
        .eng_buf    (desc_buf),
        .wb_en      (wb_en),
        .wb_data    (wb_data)
    );

    txbd_seq #(.MAX_DESC(MAX_DESC), .MIN_FRAME(MIN_FRAME)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tx_enable  (tx_enable),
        .tx_count   (tx_count),
        .desc_ctl   (desc_ctl),
        .desc_buf   (desc_buf),
        .frm_done   (frm_done),
        .frm_status (tx_stat_t'(frm_status)),
        .idx        (idx),
        .frm_req    (frm_req),
        .job        (job),
        .wb_en      (wb_en),
        .wb_data    (wb_data),
        .ev_good    (ev_good),
        .ev_err     (ev_err)
    );

    txbd_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .ev_good   (ev_good),
        .ev_err    (ev_err),
        .int_clear (int_clear),
        .int_mask  (int_mask),
        .int_src   (int_src),
        .irq       (irq)
    );

    assign frm_addr = job.addr;
    assign frm_len  = job.len;
    assign frm_pad  = job.pad;
    assign frm_crc  = job.crc;
endmodule

// File: rtl/txbd_engine_chk.sv
module txbd_engine_chk #(
    parameter int MIN_FRAME = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        tx_enable,
    input logic [1:0]  int_clear,
    input logic        frm_req,
    input logic        frm_done,
    input logic        frm_pad,
    input logic [15:0] frm_len,
    input logic [31:0] frm_addr,
    input logic [1:0]  int_src
);
    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_req) |-> $past(tx_enable)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        frm_req && !frm_done |=> frm_req && $stable(frm_addr) && $stable(frm_len)); // R3

    AST_PAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        frm_req && frm_pad |-> frm_len >= 16'(MIN_FRAME)); // R4

    AST_REQ_RETIRES: assert property (@(posedge clk) disable iff (rst)
        frm_req && frm_done |=> !frm_req); // R5

    AST_SRC_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(int_src[1]) |-> $past(frm_done)); // R7

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        int_clear[0] && !frm_done |=> !int_src[0]); // R8
endmodule

bind txbd_engine txbd_engine_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_enable (tx_enable),
    .int_clear (int_clear),
    .frm_req   (frm_req),
    .frm_done  (frm_done),
    .frm_pad   (frm_pad),
    .frm_len   (frm_len),
    .frm_addr  (frm_addr),
    .int_src   (int_src)
);

// File: tb/txbd_engine_bench.sv
module txbd_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0;
    logic [7:0]  tx_count = 8'd0;
    logic [1:0]  int_mask = 2'b00;
    logic [1:0]  int_clear = 2'b00;
    logic [7:0]  host_addr = 8'd0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        frm_req, frm_pad, frm_crc, irq;
    logic [31:0] frm_addr;
    logic [15:0] frm_len;
    logic        frm_done = 1'b0;
    logic [8:0]  frm_status = 9'd0;
    logic [1:0]  int_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txbd_engine u_txbd_engine (.*);

    typedef struct packed {
        logic [15:0] len;
        logic        pad;
        logic        crc;
        logic        irq_en;
        logic [8:0]  st;
        logic [15:0] exp_len;
        logic [1:0]  exp_src;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{16'd40,   1'b1, 1'b1, 1'b1, 9'h000, 16'd64,   2'b01},
        '{16'd40,   1'b0, 1'b1, 1'b1, 9'h002, 16'd40,   2'b01},
        '{16'd64,   1'b1, 1'b0, 1'b1, 9'h004, 16'd64,   2'b10},
        '{16'd1500, 1'b1, 1'b1, 1'b0, 9'h038, 16'd1500, 2'b00},
        '{16'd63,   1'b1, 1'b0, 1'b1, 9'h001, 16'd64,   2'b10},
        '{16'd100,  1'b0, 1'b1, 1'b1, 9'h100, 16'd100,  2'b10},
        '{16'd65,   1'b1, 1'b1, 1'b1, 9'h0F0, 16'd65,   2'b01}
    };

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(int a, logic [31:0] d);
        @(negedge clk);
        host_addr = 8'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(int a, output logic [31:0] d);
        @(negedge clk);
        host_addr = 8'(a);
        #1 d = host_rdata;
    endtask

    task automatic wait_req(int limit, output bit got);
        got = 1'b0;
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (frm_req) begin got = 1'b1; break; end
        end
    endtask

    function automatic logic [31:0] mk_ctl(logic [15:0] len, logic irq_en,
                                           logic wrap, logic pad, logic crc);
        return {len, 1'b1, irq_en, wrap, pad, crc, 2'b00, 9'h1FF};
    endfunction

    task automatic finish_frame(int idx, logic [31:0] ctl, logic [8:0] st,
                                logic [1:0] exp_src, string tag);
        logic [31:0] v, e;
        @(negedge clk);
        frm_done = 1'b1; frm_status = st;
        @(negedge clk);
        frm_done = 1'b0;
        host_rd(2 * idx, v);
        e = ctl; e[15] = 1'b0; e[8:0] = st;
        chk(v == e, {tag, " R5 write-back"}, v, e);
        chk(int_src == exp_src, {tag, " R7 source"}, 32'(int_src), 32'(exp_src));
        int_clear = 2'b11;
        @(negedge clk);
        int_clear = 2'b00;
    endtask

    task automatic do_frame(int idx, logic [31:0] ctl, logic [31:0] bufa,
                            logic [8:0] st, logic [15:0] exp_len,
                            logic [1:0] exp_src, string tag);
        bit got;
        host_wr(2 * idx + 1, bufa);
        host_wr(2 * idx, ctl);
        wait_req(40, got);
        chk(got, {tag, " R2 request"}, 32'(got), 1);
        chk(frm_addr == bufa, {tag, " R3/R6 address"}, frm_addr, bufa);
        chk(frm_len == exp_len, {tag, " R4 length"}, 32'(frm_len), 32'(exp_len));
        chk(frm_pad == ctl[12] && frm_crc == ctl[11], {tag, " R3 flags"},
            32'({frm_pad, frm_crc}), 32'(ctl[12:11]));
        finish_frame(idx, ctl, st, exp_src, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!frm_req && int_src == 2'b00 && !irq, "R1 outputs idle", 32'({frm_req, int_src, irq}), 0);
        host_rd(0, v); chk(v == 32'd0, "R1 control word zero", v, 0);
        host_rd(1, v); chk(v == 32'd0, "R1 address word zero", v, 0);

        // table walk over a four-entry ring, past its last slot (R6)
        tx_count = 8'd4; int_mask = 2'b11; tx_enable = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            do_frame(i % 4,
                     mk_ctl(VEC[i].len, VEC[i].irq_en, 1'b0, VEC[i].pad, VEC[i].crc),
                     32'h1000_0000 + 32'(i) * 32'h600,
                     VEC[i].st, VEC[i].exp_len, VEC[i].exp_src, $sformatf("vec%0d", i));
        end

        // R2: descriptor 3 not ready -> no request, index stays at 3
        host_wr(6, 32'h0040_0000);
        wait_req(12, got);
        chk(!got, "R2 unready descriptor ignored", 32'(got), 0);
        do_frame(3, mk_ctl(16'd80, 1'b1, 1'b0, 1'b0, 1'b1), 32'h2000_0300,
                 9'h000, 16'd80, 2'b01, "R2 same slot after ready");

        // R6: wrap bit inside a larger ring returns to 0
        tx_count = 8'd8;
        do_frame(0, mk_ctl(16'd70, 1'b1, 1'b1, 1'b0, 1'b1), 32'h3000_0000,
                 9'h000, 16'd70, 2'b01, "R6 wrap slot");
        host_wr(3, 32'h3000_0100);
        host_wr(2, mk_ctl(16'd90, 1'b1, 1'b0, 1'b0, 1'b1));
        wait_req(12, got);
        chk(!got, "R6 slot 1 skipped after wrap", 32'(got), 0);
        host_wr(2, 32'd0);
        do_frame(0, mk_ctl(16'd72, 1'b1, 1'b0, 1'b0, 1'b1), 32'h3000_0200,
                 9'h000, 16'd72, 2'b01, "R6 back at slot 0");

        // R9: drop enable mid-frame; frame completes, next does not start
        host_wr(3, 32'h4000_0100);
        host_wr(2, mk_ctl(16'd100, 1'b1, 1'b0, 1'b0, 1'b1));
        wait_req(40, got);
        chk(got && frm_addr == 32'h4000_0100, "R9 frame started", frm_addr, 32'h4000_0100);
        tx_enable = 1'b0;
        host_wr(5, 32'h4000_0200);
        host_wr(4, mk_ctl(16'd110, 1'b1, 1'b0, 1'b0, 1'b1));
        finish_frame(1, mk_ctl(16'd100, 1'b1, 1'b0, 1'b0, 1'b1), 9'h000, 2'b01, "R9 in-flight");
        wait_req(12, got);
        chk(!got, "R9 no start while disabled", 32'(got), 0);
        tx_enable = 1'b1;
        wait_req(40, got);
        chk(got && frm_addr == 32'h4000_0200, "R9 resumes on enable", frm_addr, 32'h4000_0200);

        // R8: masking and write-one-to-clear
        int_mask = 2'b10;
        @(negedge clk); frm_done = 1'b1; frm_status = 9'h000;
        @(negedge clk); frm_done = 1'b0;
        chk(int_src == 2'b01 && !irq, "R8 masked source keeps line low", 32'({int_src, irq}), 32'b010);
        int_mask = 2'b01;
        #1 chk(irq, "R8 unmasked source raises line", 32'(irq), 1);
        @(negedge clk); int_clear = 2'b10;
        @(negedge clk); int_clear = 2'b00;
        chk(int_src == 2'b01 && irq, "R8 clear of other bit has no effect", 32'({int_src, irq}), 32'b011);
        int_clear = 2'b01;
        @(negedge clk); int_clear = 2'b00;
        chk(int_src == 2'b00 && !irq, "R8 clear drops source and line", 32'({int_src, irq}), 0);

        // R2: zero count blocks processing
        tx_count = 8'd0;
        host_wr(6, mk_ctl(16'd64, 1'b1, 1'b0, 1'b0, 1'b1));
        wait_req(12, got);
        chk(!got, "R2 zero count idles", 32'(got), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule